// File: doc/BRIEF.md
# Instruction Queue Wakeup and Issue

This block is a small circular instruction queue sitting between an in-order enqueue stage and a set of functional units. Each slot holds one instruction: a kind, an opcode, two register operands with their valid flags and producer tags, an immediate, a target register and a PC. The slot number is the instruction's ID. Every cycle each slot watches four result buses and takes any operand whose producer tag matches a broadcast ID. Results addressed to a slot's own ID are written into its result field, and the slot is marked done.

Slots whose operands are complete are offered to two ALU lanes and one memory lane. The oldest slots, counted from the head, are offered first. A load or store is issued twice. First it goes to an ALU as an address add, using operand 1 plus the immediate. The returning sum replaces operand 1 and marks the address as formed. It then goes to the memory lane. The commit policy is reduced to a `retire` pin that pops a finished head slot.

Enqueue and the three issue lanes use valid/ready. A transfer happens on a clock edge where both are high. `enq_ready` is low only while all slots are occupied. An issue offer is not held while its ready is low: an older slot that becomes ready can take over a lane in the next cycle. The consumer must therefore accept only what is offered in the cycle it asserts ready.

Top module: `iq_wakeup_issue`

## Requirements
- R1: A slot whose operand is not yet valid captures data from any of the four buses (index 0 first ALU, 1 second ALU, 2 memory, 3 commit) whose valid bit is set and whose ID equals the operand's tag. Enqueue applies the same capture to the buses in its own cycle.
- R2: A live slot whose ID appears on bus 0, 1 or 2 stores that data as its result and becomes done. An address-add return is the exception (R6).
- R3: A slot of kind ALU (enq_kind 0) is offered on an ALU lane in the cycle after both its operands are valid, with `alu_agen` low and its operands, immediate, opcode and ID in the packet.
- R4: The ALU lanes take the ready slots in age order from the head. Lane 0 gets the oldest and lane 1 the next one, so the two lanes never carry the same ID.
- R5: A slot accepted on any lane is not offered again in the following cycle.
- R6: A load (enq_kind 1) or store (enq_kind 2) whose address is not yet formed is offered on an ALU lane with `alu_agen` high as soon as operand 1 is valid. The ALU-bus return for it replaces operand 1 and does not make the slot done.
- R7: A load with its address formed is offered on the memory lane with `mem_store` low and `mem_addr` set to the formed address. It becomes done when bus 2 returns its ID.
- R8: A store with its address formed is offered on the memory lane only when operand 2 is valid and the store is the head slot. `mem_wdata` carries operand 2, and the store becomes done when the memory lane accepts it.
- R9: `enq_slot` shows the slot the next enqueue fills, starting at 0 after reset and counting up. `enq_ready` falls when all slots are occupied.
- R10: `retire` pops the head only when the head is valid and done. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New instruction offered |
| enq_ready | output | 1 | A free slot exists |
| enq_kind | input | 2 | 0 ALU, 1 load, 2 store |
| enq_op | input | OPW | Opcode |
| enq_a1 | input | DW | Operand 1 value |
| enq_a1_ok | input | 1 | Operand 1 valid |
| enq_a1_src | input | IDW | Producer tag of operand 1 |
| enq_a2 | input | DW | Operand 2 value |
| enq_a2_ok | input | 1 | Operand 2 valid |
| enq_a2_src | input | IDW | Producer tag of operand 2 |
| enq_imm | input | DW | Immediate |
| enq_tgt | input | TGW | Target register |
| enq_pc | input | PCW | Instruction address |
| enq_slot | output | IDW | ID given to the next enqueue |
| bus_valid | input | 4 | Result bus valids |
| bus_id | input | 4 x IDW | Result bus IDs |
| bus_data | input | 4 x DW | Result bus data |
| alu_valid | output | 2 | ALU lane offers |
| alu_ready | input | 2 | ALU lane accepts |
| alu_agen | output | 2 | Lane carries an address add |
| alu_op | output | 2 x OPW | Opcode per lane |
| alu_a1 | output | 2 x DW | Operand 1 per lane |
| alu_a2 | output | 2 x DW | Operand 2 per lane |
| alu_imm | output | 2 x DW | Immediate per lane |
| alu_id | output | 2 x IDW | Slot ID per lane |
| mem_valid | output | 1 | Memory lane offer |
| mem_ready | input | 1 | Memory lane accepts |
| mem_store | output | 1 | Offer is a store |
| mem_addr | output | DW | Formed address |
| mem_wdata | output | DW | Store data |
| mem_id | output | IDW | Slot ID |
| head_valid | output | 1 | Head slot occupied |
| head_done | output | 1 | Head slot finished |
| head_id | output | IDW | Head slot ID |
| head_res | output | DW | Head result |
| head_tgt | output | TGW | Head target register |
| head_pc | output | PCW | Head PC |
| retire | input | 1 | Pop a done head |

## Verification
Every result in the block is one register away from its cause. An enqueue, a bus capture or a lane acceptance at a rising edge shows up on the combinational issue, head and enqueue outputs right after that edge, and never in the cycle of the stimulus. The bench drives each stimulus for exactly one edge and samples two nanoseconds after the edge that takes it. This holds the expected delay at one cycle for wakeup, done marking, address formation, out marking and retire. Negative cases, such as a store that is not at the head or a retire before done, are sampled in the cycle the action would have become visible.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2
  } iq_kind_t;

  localparam int NBUS = 4;
endpackage

// File: rtl/iq_snoop.sv
module iq_snoop #(
  parameter int NB = 4,
  parameter int IDW = 3,
  parameter int DW = 16,
  parameter logic [NB-1:0] MASK = '1
) (
  input  logic [IDW-1:0]         tag,
  input  logic [NB-1:0]          bv,
  input  logic [NB-1:0][IDW-1:0] bid,
  input  logic [NB-1:0][DW-1:0]  bdat,
  output logic                   hit,
  output logic [DW-1:0]          dat
);
  // lowest-numbered matching bus wins
  always_comb begin
    hit = 1'b0;
    dat = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (MASK[b] && bv[b] && bid[b] == tag) begin
        hit = 1'b1;
        dat = bdat[b];
      end
    end
  end
endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
  parameter int N = 8,
  parameter int IDW = 3,
  parameter int LANES = 2
) (
  input  logic [N-1:0]              req,
  input  logic [IDW-1:0]            head,
  output logic [LANES-1:0][IDW-1:0] sel,
  output logic [LANES-1:0]          sel_ok
);
  // age order: walk from head around the ring
  always_comb begin
    int cnt;
    logic [IDW-1:0] idx;
    cnt = 0;
    sel = '0;
    sel_ok = '0;
    for (int k = 0; k < N; k++) begin
      idx = head + IDW'(k);
      if (req[idx] && cnt < LANES) begin
        sel[cnt] = idx;
        sel_ok[cnt] = 1'b1;
        cnt = cnt + 1;
      end
    end
  end
endmodule

// File: rtl/iq_wakeup_issue.sv
module iq_wakeup_issue
  import iq_pkg::*;
#(
  parameter int N = 8,
  parameter int DW = 16,
  parameter int OPW = 4,
  parameter int TGW = 5,
  parameter int PCW = 16,
  localparam int IDW = $clog2(N),
  localparam int NALU = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  output logic                       enq_ready,
  input  logic [1:0]                 enq_kind,
  input  logic [OPW-1:0]             enq_op,
  input  logic [DW-1:0]              enq_a1,
  input  logic                       enq_a1_ok,
  input  logic [IDW-1:0]             enq_a1_src,
  input  logic [DW-1:0]              enq_a2,
  input  logic                       enq_a2_ok,
  input  logic [IDW-1:0]             enq_a2_src,
  input  logic [DW-1:0]              enq_imm,
  input  logic [TGW-1:0]             enq_tgt,
  input  logic [PCW-1:0]             enq_pc,
  output logic [IDW-1:0]             enq_slot,
  input  logic [NBUS-1:0]            bus_valid,
  input  logic [NBUS-1:0][IDW-1:0]   bus_id,
  input  logic [NBUS-1:0][DW-1:0]    bus_data,
  output logic [NALU-1:0]            alu_valid,
  input  logic [NALU-1:0]            alu_ready,
  output logic [NALU-1:0]            alu_agen,
  output logic [NALU-1:0][OPW-1:0]   alu_op,
  output logic [NALU-1:0][DW-1:0]    alu_a1,
  output logic [NALU-1:0][DW-1:0]    alu_a2,
  output logic [NALU-1:0][DW-1:0]    alu_imm,
  output logic [NALU-1:0][IDW-1:0]   alu_id,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic                       mem_store,
  output logic [DW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_wdata,
  output logic [IDW-1:0]             mem_id,
  output logic                       head_valid,
  output logic                       head_done,
  output logic [IDW-1:0]             head_id,
  output logic [DW-1:0]              head_res,
  output logic [TGW-1:0]             head_tgt,
  output logic [PCW-1:0]             head_pc,
  input  logic                       retire
);
  localparam int CW = IDW + 1;

  // slot state
  logic [N-1:0]            s_v, s_done, s_out, s_g, s_a1ok, s_a2ok;
  iq_kind_t                s_kind [N];
  logic [OPW-1:0]          s_op   [N];
  logic [DW-1:0]           s_a1   [N];
  logic [DW-1:0]           s_a2   [N];
  logic [DW-1:0]           s_imm  [N];
  logic [DW-1:0]           s_res  [N];
  logic [IDW-1:0]          s_a1t  [N];
  logic [IDW-1:0]          s_a2t  [N];
  logic [TGW-1:0]          s_tgt  [N];
  logic [PCW-1:0]          s_pc   [N];
  logic [IDW-1:0]          head, tail;
  logic [CW-1:0]           count;

  // snoop results
  logic [N-1:0]            h1, h2, hown, hagen;
  logic [DW-1:0]           d1 [N];
  logic [DW-1:0]           d2 [N];
  logic [DW-1:0]           down [N];
  logic [DW-1:0]           dagen [N];
  logic                    eh1, eh2;
  logic [DW-1:0]           ed1, ed2;

  for (genvar i = 0; i < N; i++) begin : g_slot
    iq_snoop #(.NB(NBUS), .IDW(IDW), .DW(DW), .MASK(4'b1111)) u_op1 (
      .tag(s_a1t[i]), .bv(bus_valid), .bid(bus_id), .bdat(bus_data), .hit(h1[i]), .dat(d1[i]));
    iq_snoop #(.NB(NBUS), .IDW(IDW), .DW(DW), .MASK(4'b1111)) u_op2 (
      .tag(s_a2t[i]), .bv(bus_valid), .bid(bus_id), .bdat(bus_data), .hit(h2[i]), .dat(d2[i]));
    iq_snoop #(.NB(NBUS), .IDW(IDW), .DW(DW), .MASK(4'b0111)) u_own (
      .tag(IDW'(i)), .bv(bus_valid), .bid(bus_id), .bdat(bus_data), .hit(hown[i]), .dat(down[i]));
    iq_snoop #(.NB(NBUS), .IDW(IDW), .DW(DW), .MASK(4'b0011)) u_agen (
      .tag(IDW'(i)), .bv(bus_valid), .bid(bus_id), .bdat(bus_data), .hit(hagen[i]), .dat(dagen[i]));
  end

  iq_snoop #(.NB(NBUS), .IDW(IDW), .DW(DW), .MASK(4'b1111)) u_enq1 (
    .tag(enq_a1_src), .bv(bus_valid), .bid(bus_id), .bdat(bus_data), .hit(eh1), .dat(ed1));
  iq_snoop #(.NB(NBUS), .IDW(IDW), .DW(DW), .MASK(4'b1111)) u_enq2 (
    .tag(enq_a2_src), .bv(bus_valid), .bid(bus_id), .bdat(bus_data), .hit(eh2), .dat(ed2));

  // readiness
  logic [N-1:0] alu_req, mem_req;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      alu_req[i] = s_v[i] && !s_out[i] && !s_done[i] &&
                   ((s_kind[i] == K_ALU) ? (s_a1ok[i] && s_a2ok[i]) : (!s_g[i] && s_a1ok[i]));
      mem_req[i] = s_v[i] && !s_out[i] && !s_done[i] && s_g[i] &&
                   ((s_kind[i] == K_LOAD) ||
                    (s_kind[i] == K_STORE && s_a2ok[i] && IDW'(i) == head));
    end
  end

  logic [NALU-1:0][IDW-1:0] asel;
  logic [NALU-1:0]          asel_ok;
  logic [0:0][IDW-1:0]      msel;
  logic [0:0]               msel_ok;

  iq_pick #(.N(N), .IDW(IDW), .LANES(NALU)) u_pick_alu (
    .req(alu_req), .head(head), .sel(asel), .sel_ok(asel_ok));
  iq_pick #(.N(N), .IDW(IDW), .LANES(1)) u_pick_mem (
    .req(mem_req), .head(head), .sel(msel), .sel_ok(msel_ok));

  for (genvar j = 0; j < NALU; j++) begin : g_lane
    assign alu_valid[j] = asel_ok[j];
    assign alu_agen[j]  = s_kind[asel[j]] != K_ALU;
    assign alu_op[j]    = s_op[asel[j]];
    assign alu_a1[j]    = s_a1[asel[j]];
    assign alu_a2[j]    = s_a2[asel[j]];
    assign alu_imm[j]   = s_imm[asel[j]];
    assign alu_id[j]    = asel[j];
  end

  assign mem_valid  = msel_ok[0];
  assign mem_id     = msel[0];
  assign mem_store  = s_kind[msel[0]] == K_STORE;
  assign mem_addr   = s_a1[msel[0]];
  assign mem_wdata  = s_a2[msel[0]];

  assign enq_ready  = count < CW'(N);
  assign enq_slot   = tail;
  assign head_valid = s_v[head];
  assign head_done  = s_done[head];
  assign head_id    = head;
  assign head_res   = s_res[head];
  assign head_tgt   = s_tgt[head];
  assign head_pc    = s_pc[head];

  logic enq_fire, ret_fire, mem_fire;
  logic [NALU-1:0] alu_fire;
  assign enq_fire = enq_valid && enq_ready;
  assign ret_fire = retire && s_v[head] && s_done[head];
  assign alu_fire = alu_valid & alu_ready;
  assign mem_fire = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v <= '0; s_done <= '0; s_out <= '0; s_g <= '0; s_a1ok <= '0; s_a2ok <= '0;
      head <= '0; tail <= '0; count <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!s_a1ok[i] && h1[i]) begin s_a1[i] <= d1[i]; s_a1ok[i] <= 1'b1; end
        if (!s_a2ok[i] && h2[i]) begin s_a2[i] <= d2[i]; s_a2ok[i] <= 1'b1; end
        if (s_v[i] && s_kind[i] != K_ALU && !s_g[i] && s_out[i]) begin
          if (hagen[i]) begin
            s_a1[i] <= dagen[i]; s_g[i] <= 1'b1; s_out[i] <= 1'b0;
          end
        end else if (s_v[i] && hown[i]) begin
          s_res[i] <= down[i]; s_done[i] <= 1'b1;
        end
      end
      for (int j = 0; j < NALU; j++)
        if (alu_fire[j]) s_out[asel[j]] <= 1'b1;
      if (mem_fire) begin
        s_out[msel[0]] <= 1'b1;
        if (mem_store) s_done[msel[0]] <= 1'b1;
      end
      if (enq_fire) begin
        s_v[tail]    <= 1'b1;
        s_done[tail] <= 1'b0;
        s_out[tail]  <= 1'b0;
        s_g[tail]    <= 1'b0;
        s_kind[tail] <= iq_kind_t'(enq_kind);
        s_op[tail]   <= enq_op;
        s_a1[tail]   <= enq_a1_ok ? enq_a1 : ed1;
        s_a1ok[tail] <= enq_a1_ok || eh1;
        s_a1t[tail]  <= enq_a1_src;
        s_a2[tail]   <= enq_a2_ok ? enq_a2 : ed2;
        s_a2ok[tail] <= enq_a2_ok || eh2;
        s_a2t[tail]  <= enq_a2_src;
        s_imm[tail]  <= enq_imm;
        s_tgt[tail]  <= enq_tgt;
        s_pc[tail]   <= enq_pc;
        tail         <= tail + 1'b1;
      end
      if (ret_fire) begin
        s_v[head] <= 1'b0;
        head      <= head + 1'b1;
      end
      count <= count + CW'(enq_fire) - CW'(ret_fire);
    end
  end
endmodule

// File: rtl/iq_wakeup_issue_chk.sv
module iq_wakeup_issue_chk #(
  parameter int IDW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           alu_valid,
  input logic [1:0]           alu_ready,
  input logic [1:0][IDW-1:0]  alu_id,
  input logic                 mem_valid,
  input logic                 mem_store,
  input logic [IDW-1:0]       mem_id,
  input logic [IDW-1:0]       head_id,
  input logic                 head_valid,
  input logic                 enq_ready
);
  p_lanes_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid[0] && alu_valid[1]) |-> alu_id[0] != alu_id[1]);

  p_no_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid[0] && alu_ready[0]) |=>
      !(alu_valid[0] && alu_id[0] == $past(alu_id[0])) &&
      !(alu_valid[1] && alu_id[1] == $past(alu_id[0])));

  p_no_reissue_lane1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid[1] && alu_ready[1]) |=>
      !(alu_valid[0] && alu_id[0] == $past(alu_id[1])) &&
      !(alu_valid[1] && alu_id[1] == $past(alu_id[1])));

  p_store_at_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_store) |-> mem_id == head_id);

  p_full_has_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready |-> head_valid);
endmodule

bind iq_wakeup_issue iq_wakeup_issue_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_ready(alu_ready),
  .alu_id(alu_id), .mem_valid(mem_valid), .mem_store(mem_store), .mem_id(mem_id),
  .head_id(head_id), .head_valid(head_valid), .enq_ready(enq_ready));

// File: tb/test_iq_wakeup_issue.sv
`timescale 1ns/1ps
module test_iq_wakeup_issue;
  localparam int DW = 16, OPW = 4, TGW = 5, PCW = 16, IDW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, enq_valid, enq_ready, enq_a1_ok, enq_a2_ok;
  logic [1:0] enq_kind;
  logic [OPW-1:0] enq_op;
  logic [DW-1:0] enq_a1, enq_a2, enq_imm;
  logic [IDW-1:0] enq_a1_src, enq_a2_src, enq_slot;
  logic [TGW-1:0] enq_tgt, head_tgt;
  logic [PCW-1:0] enq_pc, head_pc;
  logic [3:0] bus_valid;
  logic [3:0][IDW-1:0] bus_id;
  logic [3:0][DW-1:0] bus_data;
  logic [1:0] alu_valid, alu_ready, alu_agen;
  logic [1:0][OPW-1:0] alu_op;
  logic [1:0][DW-1:0] alu_a1, alu_a2, alu_imm;
  logic [1:0][IDW-1:0] alu_id;
  logic mem_valid, mem_ready, mem_store, head_valid, head_done, retire;
  logic [DW-1:0] mem_addr, mem_wdata, head_res;
  logic [IDW-1:0] mem_id, head_id;

  iq_wakeup_issue i_iq_wakeup_issue (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_kind(enq_kind), .enq_op(enq_op), .enq_a1(enq_a1), .enq_a1_ok(enq_a1_ok),
    .enq_a1_src(enq_a1_src), .enq_a2(enq_a2), .enq_a2_ok(enq_a2_ok),
    .enq_a2_src(enq_a2_src), .enq_imm(enq_imm), .enq_tgt(enq_tgt), .enq_pc(enq_pc),
    .enq_slot(enq_slot), .bus_valid(bus_valid), .bus_id(bus_id), .bus_data(bus_data),
    .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_agen(alu_agen), .alu_op(alu_op),
    .alu_a1(alu_a1), .alu_a2(alu_a2), .alu_imm(alu_imm), .alu_id(alu_id),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_store(mem_store),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_id(mem_id),
    .head_valid(head_valid), .head_done(head_done), .head_id(head_id),
    .head_res(head_res), .head_tgt(head_tgt), .head_pc(head_pc), .retire(retire));

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enq_valid = 0; enq_kind = 0; enq_op = 0; enq_a1 = 0; enq_a1_ok = 0;
    enq_a1_src = 0; enq_a2 = 0; enq_a2_ok = 0; enq_a2_src = 0; enq_imm = 0;
    enq_tgt = 0; enq_pc = 0; bus_valid = 0; bus_id = '0; bus_data = '0;
    alu_ready = 0; mem_ready = 0; retire = 0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic enq(input logic [1:0] k, input logic [DW-1:0] a1, input logic a1ok,
                     input logic [IDW-1:0] a1s, input logic [DW-1:0] a2, input logic a2ok,
                     input logic [IDW-1:0] a2s, input logic [DW-1:0] imm);
    enq_kind = k; enq_op = 4'h5; enq_a1 = a1; enq_a1_ok = a1ok; enq_a1_src = a1s;
    enq_a2 = a2; enq_a2_ok = a2ok; enq_a2_src = a2s; enq_imm = imm;
    enq_tgt = 5'd3; enq_pc = 16'h40; enq_valid = 1'b1;
    tick();
    enq_valid = 1'b0;
  endtask

  task automatic drive_bus(input int b, input logic [IDW-1:0] id, input logic [DW-1:0] d);
    bus_valid[b] = 1'b1; bus_id[b] = id; bus_data[b] = d;
    tick();
    bus_valid = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 ready after reset", enq_ready, 1);
    chk("R9 first slot", enq_slot, 0);
    chk("R3 no alu offer after reset", alu_valid, 0);
    chk("R7 no mem offer after reset", mem_valid, 0);
    chk("R10 empty head", head_valid, 0);
  endtask

  task automatic t_alu_basic();
    do_reset();
    enq(2'd0, 16'h3, 1, 0, 16'h4, 1, 0, 16'h0);
    chk("R3 lane0 valid", alu_valid, 2'b01);
    chk("R3 lane0 id", alu_id[0], 0);
    chk("R3 lane0 a1", alu_a1[0], 16'h3);
    chk("R3 lane0 a2", alu_a2[0], 16'h4);
    chk("R3 lane0 op", alu_op[0], 4'h5);
    chk("R3 not agen", alu_agen[0], 0);
    alu_ready = 2'b11;
    tick();
    alu_ready = 2'b00;
    chk("R5 not reoffered", alu_valid, 0);
    retire = 1'b1;
    tick();
    retire = 1'b0;
    chk("R10 retire before done ignored", head_valid, 1);
    drive_bus(0, 3'd0, 16'h7);
    chk("R2 done set", head_done, 1);
    chk("R2 result", head_res, 16'h7);
    chk("R2 head tgt", head_tgt, 5'd3);
    retire = 1'b1;
    tick();
    retire = 1'b0;
    chk("R10 popped", head_valid, 0);
  endtask

  task automatic t_wakeup();
    do_reset();
    enq(2'd0, 16'h1, 1, 0, 16'h0, 0, 3'd6, 16'h0);
    chk("R3 waits on operand", alu_valid, 0);
    drive_bus(3, 3'd6, 16'h55);
    chk("R1 commit bus wakes", alu_valid, 2'b01);
    chk("R1 captured data", alu_a2[0], 16'h55);
    bus_valid[1] = 1'b1; bus_id[1] = 3'd2; bus_data[1] = 16'h99;
    enq(2'd0, 16'h0, 0, 3'd2, 16'h8, 1, 0, 16'h0);
    bus_valid = '0;
    chk("R1 enqueue-time capture valid", alu_valid, 2'b11);
    chk("R1 enqueue-time capture data", alu_a1[1], 16'h99);
  endtask

  task automatic t_age();
    do_reset();
    for (int n = 0; n < 3; n++) enq(2'd0, 16'(n), 1, 0, 16'h0, 1, 0, 16'h0);
    chk("R4 lane0 oldest", alu_id[0], 0);
    chk("R4 lane1 next", alu_id[1], 1);
    alu_ready = 2'b11;
    tick();
    alu_ready = 2'b00;
    chk("R4 remaining on lane0", alu_id[0], 2);
    chk("R4 only one left", alu_valid, 2'b01);
  endtask

  task automatic t_load();
    do_reset();
    enq(2'd1, 16'h100, 1, 0, 16'h0, 0, 3'd7, 16'h4);
    chk("R6 agen offer", alu_agen[0], 1);
    chk("R6 agen base", alu_a1[0], 16'h100);
    chk("R6 agen imm", alu_imm[0], 16'h4);
    chk("R7 no mem before address", mem_valid, 0);
    alu_ready = 2'b01;
    tick();
    alu_ready = 2'b00;
    drive_bus(0, 3'd0, 16'h104);
    chk("R6 agen not done", head_done, 0);
    chk("R7 load offered", mem_valid, 1);
    chk("R7 load addr", mem_addr, 16'h104);
    chk("R7 is load", mem_store, 0);
    mem_ready = 1'b1;
    tick();
    mem_ready = 1'b0;
    chk("R5 mem not reoffered", mem_valid, 0);
    drive_bus(2, 3'd0, 16'hBEEF);
    chk("R7 load done", head_done, 1);
    chk("R7 load data", head_res, 16'hBEEF);
  endtask

  task automatic t_store();
    do_reset();
    enq(2'd0, 16'h0, 0, 3'd5, 16'h2, 1, 0, 16'h0);
    enq(2'd2, 16'h20, 1, 0, 16'h0, 0, 3'd4, 16'h0);
    chk("R6 store agen id", alu_id[0], 1);
    alu_ready = 2'b01;
    tick();
    alu_ready = 2'b00;
    drive_bus(0, 3'd1, 16'h20);
    drive_bus(2, 3'd4, 16'h77);
    chk("R8 store waits for head", mem_valid, 0);
    drive_bus(3, 3'd5, 16'h1);
    alu_ready = 2'b01;
    tick();
    alu_ready = 2'b00;
    drive_bus(0, 3'd0, 16'h3);
    chk("R8 still not head", mem_valid, 0);
    retire = 1'b1;
    tick();
    retire = 1'b0;
    chk("R8 store offered at head", mem_valid, 1);
    chk("R8 store flag", mem_store, 1);
    chk("R8 store data", mem_wdata, 16'h77);
    chk("R8 store id", mem_id, 1);
    mem_ready = 1'b1;
    tick();
    mem_ready = 1'b0;
    chk("R8 store done", head_done, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int n = 0; n < 8; n++) begin
      chk("R9 slot order", enq_slot, 32'(n));
      enq(2'd0, 16'h0, 0, 3'd7, 16'h0, 0, 3'd7, 16'h0);
    end
    chk("R9 full", enq_ready, 0);
    enq(2'd0, 16'h0, 1, 0, 16'h0, 1, 0, 16'h0);
    chk("R9 blocked enqueue no offer", alu_valid, 0);
    retire = 1'b1;
    tick();
    retire = 1'b0;
    chk("R10 head kept", head_id, 0);
    chk("R10 still full", enq_ready, 0);
  endtask

  initial begin
    #3000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alu_basic();
    t_wakeup();
    t_age();
    t_load();
    t_store();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule